// File: doc/BRIEF.md
# Transmit descriptor ring gatherer

This block walks a circular ring of 16-byte transmit descriptors held in host memory. Each descriptor names one buffer fragment. The block reads fragments through a single-word memory request port, joins the fragments of a chain into one frame, and sends that frame out as a byte stream. It then hands the descriptors back to software and raises a one-cycle transmit interrupt.

A scan pass starts on a transmit-demand pulse or on a periodic poll tick. A pass sends at most 16 frames. It ends at the first frame that cannot be started or finished. The ring base, the ring size exponent, the run flag and the descriptor layout select are plain inputs, and they must stay steady while `busy` is high.

The frame is held in an internal buffer until its chain is complete, so a broken chain never reaches the stream. The stream uses valid/ready. Once `tx_valid` is raised, `tx_data` and `tx_last` do not change until a cycle with `tx_ready` high takes the byte. The sink may hold `tx_ready` low for any number of cycles. The memory port uses a request/acknowledge handshake. `mem_req`, `mem_we`, `mem_addr` and `mem_wdata` stay steady until `mem_ack`. For a read, `mem_rdata` is valid in the acknowledge cycle.

Top module: `txring_gather`

## Requirements
- R1: While `tx_run` is low or `ring_base` is zero, a pass makes no memory request, emits no byte and raises no interrupt.
- R2: A frame starts only if the flags word of the current descriptor has bit 31 (device owns) set. If that bit is clear, the pass ends after that single flags read, with no write.
- R3: Descriptor n sits at `ring_base + 16*n`. The flags word is at offset 4. The buffer address is at offset 0 when `fmt_swap` is 0, and at offset 8 when `fmt_swap` is 1.
- R4: A fragment holds `(-flags[11:0]) mod 4096` bytes, taken from the buffer address upward. The byte at address a is bits `8*a[1:0]+7 : 8*a[1:0]` of the 32-bit word at `a & ~3`.
- R5: Only the first 2048 bytes of a frame are emitted. The remaining fragment bytes are still consumed.
- R6: A descriptor whose flags bit 25 (start of packet) is clear is written back after its data is read. The written flags are the read value with bit 31 cleared.
- R7: After each fragment the ring position advances by one and wraps to 0 at `2^ring_log2` descriptors, with the ring size capped at 512. Flags bit 24 (end of packet) closes the frame.
- R8: If the next descriptor of an open chain is not owned, nothing is emitted, no interrupt fires and the first descriptor is not written. The pass then ends with the position left at the unowned descriptor.
- R9: A closed frame with nonzero length is emitted as one burst whose last byte carries `tx_last`. Whatever the length, the first descriptor's flags are then written back with bit 31 cleared, and `tx_irq` pulses for one cycle.
- R10: One pass completes at most 16 frames.
- R11: The stream obeys valid/ready. Bytes leave in gather order and stay stable while stalled.
- R12: `busy` is low after reset and rises in the cycle after a trigger. It stays high until the pass ends. Triggers that arrive during a pass are ignored.
- R13: A memory request keeps its address, direction and write data steady until it is acknowledged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ring_base | input | 32 | Byte address of descriptor 0; 0 disables transmission |
| ring_log2 | input | 4 | Ring size exponent (capped at 9) |
| tx_run | input | 1 | Transmitter enabled |
| fmt_swap | input | 1 | 0: buffer address at offset 0; 1: at offset 8 |
| kick | input | 1 | Transmit-demand pulse |
| poll_tick | input | 1 | Periodic poll pulse |
| busy | output | 1 | Pass in progress |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted; read data valid |
| mem_rdata | input | 32 | Read data |
| tx_valid | output | 1 | Stream byte valid |
| tx_ready | input | 1 | Stream sink ready |
| tx_data | output | 8 | Stream byte |
| tx_last | output | 1 | Final byte of frame |
| tx_irq | output | 1 | One-cycle transmit interrupt |

## Verification
The hardest state to reach is an open chain that hits a descriptor software has not yet handed over. The frame must then vanish, and the next pass must resume exactly at that stalled slot. Directed rings build such a chain and then release the stalled slot, so the resumed frame can be compared. Random rings, with a random owned bit, random start and end flags, random fragment sizes and unaligned buffer addresses, are scored against a bench model of the whole ring walk. The model predicts the emitted bytes, the interrupt count and the final memory image. Memory latency and sink back-pressure are both random. Separate directed cases cover the 2048-byte truncation and the 16-frame pass limit.

// File: rtl/txr_pkg.sv
package txr_pkg;
  typedef enum logic [3:0] {
    S_IDLE, S_CHK, S_FLAGS, S_ADDR, S_FETCH, S_BYTE,
    S_WB, S_NEXT, S_EMIT, S_REL, S_IRQ
  } txr_state_e;

  localparam int OWN_BIT = 31;
  localparam int SOP_BIT = 25;
  localparam int EOP_BIT = 24;

  // fragment size is the negated 12-bit count field
  function automatic logic [11:0] frag_bytes(input logic [11:0] f);
    return ~f + 12'd1;
  endfunction
endpackage

// File: rtl/txr_ring_pos.sv
module txr_ring_pos #(
  parameter int MAX_LOG2 = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [3:0]          len_log2,
  input  logic                adv,
  output logic [MAX_LOG2-1:0] pos
);
  localparam int LEN_W = MAX_LOG2 + 1;

  logic [LEN_W-1:0] ring_len;
  logic [LEN_W-1:0] pos_inc;

  always_comb begin
    if (len_log2 >= 4'(MAX_LOG2)) ring_len = LEN_W'(1) << MAX_LOG2;
    else                          ring_len = LEN_W'(1) << len_log2;
    pos_inc = {1'b0, pos} + LEN_W'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)   pos <= '0;
    else if (adv) pos <= (pos_inc == ring_len) ? '0 : pos_inc[MAX_LOG2-1:0];
  end

  AST_POS_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    adv |=> (pos == '0) || (pos == $past(pos) + 1'b1)); // R7
endmodule

// File: rtl/txr_frame_buf.sv
module txr_frame_buf #(
  parameter int MAX_BYTES = 2048
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic                                 clr,
  input  logic                                 wr_en,
  input  logic [7:0]                           wr_byte,
  input  logic                                 start,
  input  logic                                 out_ready,
  output logic                                 out_valid,
  output logic [7:0]                           out_data,
  output logic                                 out_last,
  output logic                                 done,
  output logic [$clog2(MAX_BYTES+1)-1:0]       fill
);
  localparam int CNT_W = $clog2(MAX_BYTES + 1);
  localparam int IDX_W = $clog2(MAX_BYTES);

  logic [7:0]       store [MAX_BYTES];
  logic             active;
  logic [CNT_W-1:0] rd_idx;
  logic             full;

  assign full = (fill == CNT_W'(MAX_BYTES));

  always_ff @(posedge clk) begin
    if (wr_en && !full) store[fill[IDX_W-1:0]] <= wr_byte;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr)        fill <= '0;
    else if (wr_en && !full)  fill <= fill + 1'b1;
  end

  assign out_valid = active;
  assign out_data  = store[rd_idx[IDX_W-1:0]];
  assign out_last  = active && (rd_idx == fill - CNT_W'(1));
  assign done      = out_valid && out_ready && out_last;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active <= 1'b0;
      rd_idx <= '0;
    end else if (start) begin
      active <= 1'b1;
      rd_idx <= '0;
    end else if (out_valid && out_ready) begin
      if (out_last) active <= 1'b0;
      else          rd_idx <= rd_idx + 1'b1;
    end
  end

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last)); // R11
  AST_NO_FILL_WHILE_SENDING: assert property (@(posedge clk) disable iff (!rst_n)
    active |-> !wr_en); // R9
endmodule

// File: rtl/txring_gather.sv
module txring_gather #(
  parameter int ADDR_W        = 32,
  parameter int MAX_FRAME     = 2048,
  parameter int PASS_MAX      = 16,
  parameter int RING_LOG2_MAX = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] ring_base,
  input  logic [3:0]        ring_log2,
  input  logic              tx_run,
  input  logic              fmt_swap,
  input  logic              kick,
  input  logic              poll_tick,
  output logic              busy,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [31:0]       mem_wdata,
  input  logic              mem_ack,
  input  logic [31:0]       mem_rdata,
  output logic              tx_valid,
  input  logic              tx_ready,
  output logic [7:0]        tx_data,
  output logic              tx_last,
  output logic              tx_irq
);
  import txr_pkg::*;

  localparam int PC_W  = $clog2(PASS_MAX + 1);
  localparam int CNT_W = $clog2(MAX_FRAME + 1);
  localparam logic [31:0] OWN_MASK = 32'h1 << OWN_BIT;

  txr_state_e               state;
  logic [31:0]              flags, first_flags, word;
  logic [ADDR_W-1:0]        first_addr, buf_addr, desc_addr;
  logic [11:0]              left;
  logic                     first_desc;
  logic [PC_W-1:0]          pass_cnt;
  logic [RING_LOG2_MAX-1:0] pos;
  logic [CNT_W-1:0]         fill;
  logic [7:0]               lane_byte;
  logic                     buf_clr, buf_wr, buf_start, buf_done, pos_adv;
  logic [11:0]              frag_n;

  txr_ring_pos #(.MAX_LOG2(RING_LOG2_MAX)) u_pos (
    .clk(clk), .rst_n(rst_n), .len_log2(ring_log2), .adv(pos_adv), .pos(pos)
  );

  txr_frame_buf #(.MAX_BYTES(MAX_FRAME)) u_buf (
    .clk(clk), .rst_n(rst_n), .clr(buf_clr), .wr_en(buf_wr), .wr_byte(lane_byte),
    .start(buf_start), .out_ready(tx_ready), .out_valid(tx_valid),
    .out_data(tx_data), .out_last(tx_last), .done(buf_done), .fill(fill)
  );

  assign desc_addr = ring_base + ADDR_W'({pos, 4'b0000});
  assign lane_byte = word[{buf_addr[1:0], 3'b000} +: 8];
  assign frag_n    = frag_bytes(mem_rdata[11:0] & 12'hFFF) ;
  assign buf_clr   = (state == S_CHK);
  assign buf_wr    = (state == S_BYTE);
  assign pos_adv   = (state == S_NEXT);
  assign buf_start = (state == S_NEXT) && flags[EOP_BIT] && (fill != '0);
  assign tx_irq    = (state == S_IRQ);
  assign busy      = (state != S_IDLE);

  always_comb begin
    mem_req   = 1'b0;
    mem_we    = 1'b0;
    mem_addr  = '0;
    mem_wdata = '0;
    case (state)
      S_FLAGS: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + ADDR_W'(4);
      end
      S_ADDR: begin
        mem_req  = 1'b1;
        mem_addr = desc_addr + (fmt_swap ? ADDR_W'(8) : ADDR_W'(0));
      end
      S_FETCH: begin
        mem_req  = 1'b1;
        mem_addr = {buf_addr[ADDR_W-1:2], 2'b00};
      end
      S_WB: begin
        mem_req   = !flags[SOP_BIT];
        mem_we    = !flags[SOP_BIT];
        mem_addr  = desc_addr + ADDR_W'(4);
        mem_wdata = flags & ~OWN_MASK;
      end
      S_REL: begin
        mem_req   = 1'b1;
        mem_we    = 1'b1;
        mem_addr  = first_addr + ADDR_W'(4);
        mem_wdata = first_flags & ~OWN_MASK;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      flags       <= '0;
      first_flags <= '0;
      first_addr  <= '0;
      buf_addr    <= '0;
      word        <= '0;
      left        <= '0;
      first_desc  <= 1'b0;
      pass_cnt    <= '0;
    end else begin
      case (state)
        S_IDLE: if (kick || poll_tick) begin
          pass_cnt <= '0;
          state    <= S_CHK;
        end
        S_CHK: begin
          if (!tx_run || ring_base == '0 || pass_cnt == PC_W'(PASS_MAX)) state <= S_IDLE;
          else begin
            first_desc <= 1'b1;
            state      <= S_FLAGS;
          end
        end
        S_FLAGS: if (mem_ack) begin
          flags <= mem_rdata;
          if (!mem_rdata[OWN_BIT]) state <= S_IDLE;
          else begin
            if (first_desc) begin
              first_flags <= mem_rdata;
              first_addr  <= desc_addr;
            end
            state <= S_ADDR;
          end
        end
        S_ADDR: if (mem_ack) begin
          buf_addr <= mem_rdata;
          left     <= frag_bytes(flags[11:0]);
          state    <= (frag_bytes(flags[11:0]) == 12'd0) ? S_WB : S_FETCH;
        end
        S_FETCH: if (mem_ack) begin
          word  <= mem_rdata;
          state <= S_BYTE;
        end
        S_BYTE: begin
          buf_addr <= buf_addr + 1'b1;
          left     <= left - 1'b1;
          if (left == 12'd1)              state <= S_WB;
          else if (buf_addr[1:0] == 2'd3) state <= S_FETCH;
        end
        S_WB: if (flags[SOP_BIT] || mem_ack) state <= S_NEXT;
        S_NEXT: begin
          first_desc <= 1'b0;
          if (flags[EOP_BIT]) state <= (fill != '0) ? S_EMIT : S_REL;
          else                state <= S_FLAGS;
        end
        S_EMIT: if (buf_done) state <= S_REL;
        S_REL:  if (mem_ack)  state <= S_IRQ;
        S_IRQ: begin
          pass_cnt <= pass_cnt + 1'b1;
          state    <= S_CHK;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_ack |=> mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)); // R13
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !tx_valid && !tx_irq); // R1
  AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |=> !tx_irq); // R9
  AST_PASS_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_irq |-> pass_cnt < PC_W'(PASS_MAX)); // R10
  AST_NO_IRQ_MIDSEND: assert property (@(posedge clk) disable iff (!rst_n)
    tx_valid |-> !tx_irq && !mem_req); // R9
endmodule

// File: tb/txring_gather_tb.sv
module txring_gather_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] ring_base = 32'h100;
  logic [3:0]  ring_log2 = 4'd3;
  logic        tx_run = 1'b1, fmt_swap = 1'b0, kick = 1'b0, poll_tick = 1'b0;
  logic        busy, mem_req, mem_we, mem_ack = 1'b0, tx_valid, tx_ready = 1'b0, tx_last, tx_irq;
  logic [31:0] mem_addr, mem_wdata, mem_rdata = '0;
  logic [7:0]  tx_data;

  always #10 clk = ~clk;

  txring_gather u_dut (
    .clk(clk), .rst_n(rst_n), .ring_base(ring_base), .ring_log2(ring_log2),
    .tx_run(tx_run), .fmt_swap(fmt_swap), .kick(kick), .poll_tick(poll_tick),
    .busy(busy), .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
    .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
    .tx_last(tx_last), .tx_irq(tx_irq)
  );

  int n_chk = 0, n_fail = 0;
  logic [31:0] bm [1024];
  logic [31:0] sh [1024];
  logic [7:0]  exp_q[$], act_q[$];
  int          exp_len[$], act_len[$];
  int cur_len = 0, act_irq = 0, exp_irq = 0, ack_cnt = 0, req_viol = 0, out_viol = 0;
  int ref_pos = 0;
  logic [1:0]  wait_c = 2'd0;
  logic        req_held = 1'b0, out_hold = 1'b0;
  logic [31:0] held_addr = '0;
  logic [7:0]  hold_data = '0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // memory responder, stream sink and monitors, all away from the active edge
  always @(negedge clk) begin
    bit r;
    if (mem_ack) begin
      mem_ack  <= 1'b0;
      req_held <= 1'b0;
    end else if (mem_req) begin
      if (req_held && mem_addr != held_addr) req_viol++;
      if (wait_c == 2'd0) begin
        mem_ack   <= 1'b1;
        mem_rdata <= bm[mem_addr[11:2]];
        if (mem_we) bm[mem_addr[11:2]] <= mem_wdata;
        ack_cnt++;
        wait_c   <= 2'($urandom % 3);
        req_held <= 1'b0;
      end else begin
        wait_c    <= wait_c - 2'd1;
        req_held  <= 1'b1;
        held_addr <= mem_addr;
      end
    end
    if (tx_irq) act_irq++;
    r = ($urandom % 4) != 0;
    if (out_hold && (!tx_valid || tx_data != hold_data)) out_viol++;
    if (tx_valid && r) begin
      act_q.push_back(tx_data);
      cur_len++;
      if (tx_last) begin
        act_len.push_back(cur_len);
        cur_len = 0;
      end
      out_hold = 1'b0;
    end else begin
      out_hold  = tx_valid;
      hold_data = tx_data;
    end
    tx_ready <= r;
  end

  function automatic logic [31:0] rdw(input logic [31:0] a);
    return sh[a[11:2]];
  endfunction

  function automatic logic [7:0] rdb(input logic [31:0] a);
    logic [31:0] w;
    w = sh[a[11:2]];
    return w[8*a[1:0] +: 8];
  endfunction

  function automatic logic [31:0] mkfl(input bit own, input bit sop, input bit eop, input int n);
    return {own, 5'b0, sop, eop, 12'b0, 12'(4096 - n)};
  endfunction

  function automatic int ring_len();
    return (ring_log2 >= 4'd9) ? 512 : (1 << ring_log2);
  endfunction

  task automatic put_desc(input int idx, input logic [31:0] fl, input logic [31:0] ba);
    logic [31:0] d;
    d = ring_base + 32'(idx * 16);
    bm[(d + 4) >> 2]                  = fl;
    bm[(d + (fmt_swap ? 8 : 0)) >> 2] = ba;
    bm[(d + (fmt_swap ? 0 : 8)) >> 2] = $urandom;
    bm[(d + 12) >> 2]                 = $urandom;
  endtask

  // bench model of one scan pass on the shadow image
  task automatic ref_pass();
    logic [31:0] d, fl, fd, ffl, a;
    logic [7:0]  tmp[$];
    int n;
    bit ok;
    for (int fr = 0; fr < 16; fr++) begin
      if (!tx_run || ring_base == 0) break;
      d  = ring_base + 32'(ref_pos * 16);
      fl = rdw(d + 4);
      if (!fl[31]) break;
      fd = d; ffl = fl; tmp.delete(); ok = 1'b1;
      forever begin
        a = rdw(d + (fmt_swap ? 8 : 0));
        n = (4096 - int'(fl[11:0])) % 4096;
        for (int i = 0; i < n; i++) if (tmp.size() < 2048) tmp.push_back(rdb(a + 32'(i)));
        if (!fl[25]) sh[(d + 4) >> 2] = fl & 32'h7FFF_FFFF;
        ref_pos = (ref_pos + 1 == ring_len()) ? 0 : ref_pos + 1;
        if (fl[24]) break;
        d  = ring_base + 32'(ref_pos * 16);
        fl = rdw(d + 4);
        if (!fl[31]) begin ok = 1'b0; break; end
      end
      if (!ok) break;
      if (tmp.size() > 0) begin
        foreach (tmp[k]) exp_q.push_back(tmp[k]);
        exp_len.push_back(tmp.size());
      end
      sh[(fd + 4) >> 2] = ffl & 32'h7FFF_FFFF;
      exp_irq++;
    end
  endtask

  task automatic run_pass(input bit use_poll);
    int c, bad, mem_bad;
    for (int i = 0; i < 1024; i++) sh[i] = bm[i];
    exp_q.delete(); act_q.delete(); exp_len.delete(); act_len.delete();
    exp_irq = 0; act_irq = 0;
    ref_pass();
    @(negedge clk);
    if (use_poll) poll_tick = 1'b1; else kick = 1'b1;
    @(negedge clk);
    poll_tick = 1'b0; kick = 1'b0;
    chk(busy == 1'b1, "R12 busy after trigger", busy, 1);
    kick = 1'b1;  // extra trigger during the pass must be ignored
    @(negedge clk);
    kick = 1'b0;
    c = 0;
    while (busy && c < 40000) begin @(negedge clk); c++; end
    repeat (3) @(negedge clk);
    chk(act_len.size() == exp_len.size(), "R9 frame count", act_len.size(), exp_len.size());
    bad = 0;
    if (act_q.size() != exp_q.size()) bad = 1;
    else foreach (exp_q[k]) if (act_q[k] != exp_q[k]) bad++;
    chk(bad == 0, "R3 R4 R7 R11 frame bytes", act_q.size(), exp_q.size());
    chk(act_irq == exp_irq, "R9 interrupt count", act_irq, exp_irq);
    mem_bad = 0;
    for (int i = 0; i < 1024; i++) if (bm[i] !== sh[i]) mem_bad++;
    chk(mem_bad == 0, "R6 R8 write-back image", mem_bad, 0);
  endtask

  task automatic clear_ring();
    for (int i = 0; i < ring_len(); i++) put_desc(i, 32'h0, 32'h400);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected idle");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    int a0, base_acks;
    void'($urandom(32'd1234));
    for (int i = 0; i < 1024; i++) bm[i] = $urandom;
    clear_ring();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !tx_valid && !mem_req && !tx_irq, "R12 R1 reset state", busy, 0);

    // R1: run low, then base zero
    put_desc(0, mkfl(1, 1, 1, 4), 32'h400);
    tx_run = 1'b0; a0 = ack_cnt;
    run_pass(1'b0);
    chk(ack_cnt == a0, "R1 no traffic when run low", ack_cnt - a0, 0);
    tx_run = 1'b1; ring_base = 32'h0; a0 = ack_cnt;
    run_pass(1'b1);
    chk(ack_cnt == a0, "R1 no traffic when base zero", ack_cnt - a0, 0);
    ring_base = 32'h100;

    // R2: current descriptor not owned
    clear_ring(); a0 = ack_cnt;
    run_pass(1'b0);
    chk(ack_cnt - a0 == 1, "R2 single flags read", ack_cnt - a0, 1);

    // R8: underflow, then resume at the stalled slot
    clear_ring();
    put_desc(ref_pos, mkfl(1, 1, 0, 5), 32'h402);
    run_pass(1'b0);
    chk(act_irq == 0 && act_len.size() == 0, "R8 nothing sent on underflow", act_irq, 0);
    put_desc(ref_pos, mkfl(1, 1, 1, 3), 32'h513);
    run_pass(1'b0);
    chk(act_len.size() == 1 && act_len[0] == 3, "R8 resume at stalled descriptor",
        act_len.size() > 0 ? act_len[0] : -1, 3);

    // R5: 3000-byte chain truncated to 2048
    clear_ring();
    put_desc(ref_pos, mkfl(1, 1, 0, 1500), 32'h400);
    put_desc((ref_pos + 1) % 8, mkfl(1, 0, 1, 1500), 32'h401);
    run_pass(1'b1);
    chk(act_len.size() == 1 && act_len[0] == 2048, "R5 frame cap",
        act_len.size() > 0 ? act_len[0] : -1, 2048);

    // random rings
    for (int p = 0; p < 40; p++) begin
      fmt_swap = 1'($urandom % 2);
      for (int i = 0; i < 8; i++)
        put_desc(i, mkfl(($urandom % 4) != 0, 1'($urandom % 2),
                         (i == 7) || ($urandom % 2), $urandom % 25),
                 32'h400 + ($urandom % 32'hB00));
      run_pass(1'($urandom % 2));
    end

    // R10: 32 single-descriptor frames need two passes
    fmt_swap = 1'b0; ring_log2 = 4'd5;
    for (int i = 0; i < 32; i++) put_desc(i, mkfl(1, 1, 1, 1 + i % 3), 32'h600 + 32'(i));
    base_acks = 0;
    run_pass(1'b0);
    chk(act_irq == 16, "R10 first pass bound", act_irq, 16);
    run_pass(1'b1);
    chk(act_irq == 16, "R10 second pass bound", act_irq, 16);
    run_pass(1'b0);
    chk(act_irq == base_acks, "R10 drained ring", act_irq, 0);

    chk(req_viol == 0, "R13 request stability", req_viol, 0);
    chk(out_viol == 0, "R11 stream stability", out_viol, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule